// File: doc/BRIEF.md
# Edge-Interval Bit-Rate Validator

This block sits behind the demodulator of a wake-up receiver and decides whether the incoming data has a plausible bit rate before the rest of the receive path is woken. Once enabled, it first waits through a fixed startup period during which the data line is not trusted. It then times the gap between successive data transitions. The timer is a counter that advances on a slow sampling tick. Each gap must fall inside a window set by a lower and an upper limit.

A gap that ends too early fails the check. A gap that runs up to the upper limit also fails, as soon as the count reaches that limit, without waiting for a transition. After a failure the block drops to sleep and stays there until it is disabled. After a set number of passing gaps in a row, it enters a receive state and holds there until it is disabled.

The data line is a level that is sampled asynchronously, not a stream. There is therefore no valid/ready handshake and no back-pressure. Every pin is plain control or status, and the pulse outputs last one clock and cannot be stalled.

Top module: `bitrate_gate`

## Requirements
- R1: After reset, `mode` is 0 (sleep), `pass_pulse` and `fail_pulse` are low, and `done` is low. The mode codes are: 0 sleep, 1 startup, 2 check, 3 receive.
- R2: With `en` high in sleep, the block enters startup (code 1). It stays there for exactly START_TICKS sampling ticks and then enters check (code 2). Data transitions during startup produce no pulse.
- R3: `dem_in` passes through a two-flop synchronizer. Rising and falling transitions are both treated as edges. The first edge seen in check mode is not judged: it only starts timing, with the counter set to 1.
- R4: In check mode the counter advances by 1 on each cycle with `tick` high. An edge with lower limit <= count < upper limit raises `pass_pulse` for one cycle and restarts the counter at 1.
- R5: An edge while the count is below the lower limit raises `fail_pulse` for one cycle and puts the block in sleep with the counter at 0.
- R6: When a tick would bring the count to the upper limit, `fail_pulse` is raised and the block goes to sleep, with no edge needed.
- R7: When the lower limit is equal to or above the upper limit, every judged edge fails.
- R8: `lo_lim` and `hi_lim` are captured only while the block is in sleep. Changes made during startup or check have no effect on the current check.
- R9: After PASS_GOAL consecutive passes, the block enters receive (code 3) and `done` goes high. It then raises no further pulses, whatever happens on the data line, until `en` goes low.
- R10: `en` low returns the block to sleep on the next clock from any mode, with no `fail_pulse`. After a failure the block stays in sleep while `en` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces sleep |
| dem_in | input | 1 | Demodulated data level, asynchronous |
| tick | input | 1 | Sampling-clock enable, one cycle wide |
| lo_lim | input | CNT_W | Lower interval limit, inclusive |
| hi_lim | input | CNT_W | Upper interval limit, exclusive |
| mode | output | 2 | Current mode code |
| pass_pulse | output | 1 | One-cycle pulse per passing interval |
| fail_pulse | output | 1 | One-cycle pulse on a failed check |
| done | output | 1 | High while in receive mode |

## Verification
The hardest cases to reach from the ports are gaps that end exactly one count below the lower limit or exactly at the upper limit. Hitting them depends on where the synchronizer latency falls relative to the sampling ticks. The stimulus toggles the data line on the cycle just after a tick, so each edge is handled before the next tick. The count at the edge is then exactly the number of ticks waited plus one. This lets the vector table place intervals on either side of each limit, and also hold an interval open until the timer itself overflows. The limit-freeze case is reached by changing the limit inputs after check mode has been entered, then timing an interval that only the captured limits accept.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [1:0] {
    M_SLEEP   = 2'd0,
    M_STARTUP = 2'd1,
    M_CHECK   = 2'd2,
    M_RECEIVE = 2'd3
  } bg_mode_e;
endpackage

// File: rtl/bg_sync_edge.sv
module bg_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // Either polarity counts as an edge (R3).
  assign edge_o = s2_q ^ prev_q;
endmodule

// File: rtl/bg_interval.sv
module bg_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         one,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (one) cnt_q <= W'(1);
    else if (inc) cnt_q <= cnt_q + W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bitrate_gate.sv
module bitrate_gate #(
  parameter int CNT_W       = 8,
  parameter int START_TICKS = 4,
  parameter int PASS_GOAL   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dem_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] lo_lim,
  input  logic [CNT_W-1:0] hi_lim,
  output logic [1:0]       mode,
  output logic             pass_pulse,
  output logic             fail_pulse,
  output logic             done
);
  import bg_pkg::*;

  localparam int SU_W = $clog2(START_TICKS + 1);
  localparam int NP_W = $clog2(PASS_GOAL + 1);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(START_TICKS - 1);
  localparam logic [NP_W-1:0] NP_LAST = NP_W'(PASS_GOAL - 1);

  bg_mode_e         mode_q, mode_d;
  logic [SU_W-1:0]  su_q, su_d;
  logic [NP_W-1:0]  np_q, np_d;
  logic             armed_q, armed_d;
  logic             hold_q, hold_d;
  logic             pass_q, pass_d, fail_q, fail_d;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic             edge_s;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_one, cnt_inc;
  logic             in_win;
  logic [CNT_W:0]   cnt_nxt;

  bg_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .din(dem_in), .edge_o(edge_s)
  );

  bg_interval #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .one(cnt_one),
    .inc(cnt_inc), .cnt(cnt)
  );

  // An empty window (lo >= hi) rejects every edge by itself (R7).
  assign in_win  = (cnt >= lo_q) && (cnt < hi_q);
  assign cnt_nxt = {1'b0, cnt} + (CNT_W+1)'(1);

  always_comb begin
    mode_d  = mode_q;
    su_d    = su_q;
    np_d    = np_q;
    armed_d = armed_q;
    hold_d  = hold_q;
    pass_d  = 1'b0;
    fail_d  = 1'b0;
    cnt_clr = 1'b0;
    cnt_one = 1'b0;
    cnt_inc = 1'b0;
    if (!en) begin
      mode_d  = M_SLEEP;
      hold_d  = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (mode_q)
        M_SLEEP: begin
          if (!hold_q) begin
            mode_d  = M_STARTUP;
            su_d    = '0;
            cnt_clr = 1'b1;
          end
        end
        M_STARTUP: begin
          if (tick) begin
            if (su_q == SU_LAST) begin
              mode_d  = M_CHECK;
              armed_d = 1'b0;
              np_d    = '0;
              cnt_clr = 1'b1;
            end else begin
              su_d = su_q + SU_W'(1);
            end
          end
        end
        M_CHECK: begin
          if (edge_s) begin
            if (!armed_q) begin
              armed_d = 1'b1;
              cnt_one = 1'b1;
            end else if (in_win) begin
              pass_d  = 1'b1;
              cnt_one = 1'b1;
              if (np_q == NP_LAST) mode_d = M_RECEIVE;
              else                 np_d   = np_q + NP_W'(1);
            end else begin
              fail_d  = 1'b1;
              hold_d  = 1'b1;
              mode_d  = M_SLEEP;
              cnt_clr = 1'b1;
            end
          end else if (tick) begin
            if (cnt_nxt >= {1'b0, hi_q}) begin
              fail_d  = 1'b1;
              hold_d  = 1'b1;
              mode_d  = M_SLEEP;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_SLEEP;
      su_q    <= '0;
      np_q    <= '0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      su_q    <= su_d;
      np_q    <= np_d;
      armed_q <= armed_d;
      hold_q  <= hold_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      if (mode_q == M_SLEEP) begin
        lo_q <= lo_lim;
        hi_q <= hi_lim;
      end
    end
  end

  assign mode       = mode_q;
  assign pass_pulse = pass_q;
  assign fail_pulse = fail_q;
  assign done       = (mode_q == M_RECEIVE);

  a_r4_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q));

  a_r5_fail_lands_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> mode_q == M_SLEEP);

  a_r6_count_below_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CHECK && hi_q != '0) |-> cnt < hi_q);

  a_r2_check_after_startup: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CHECK) |-> ($past(mode_q) == M_STARTUP || $past(mode_q) == M_CHECK));

  a_r8_limits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_SLEEP && $past(mode_q) != M_SLEEP) |-> ($stable(lo_q) && $stable(hi_q)));

  a_r9_receive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RECEIVE && $past(mode_q) == M_RECEIVE) |-> (!pass_q && !fail_q));

  a_r10_disable_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (mode_q == M_SLEEP && !fail_q));
endmodule

// File: tb/sim_bitrate_gate.sv
module sim_bitrate_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       dem = 1'b0;
  logic [1:0] tdiv;
  logic       tick;
  logic [7:0] lo = 8'd14, hi = 8'd24;
  logic [1:0] mode;
  logic       pass_pulse, fail_pulse, done;
  int checks = 0, errors = 0, pc = 0, fc = 0, cyc = 0;

  always #4 clk = ~clk;

  bitrate_gate u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dem_in(dem), .tick(tick),
    .lo_lim(lo), .hi_lim(hi), .mode(mode), .pass_pulse(pass_pulse),
    .fail_pulse(fail_pulse), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0; else tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  always @(posedge clk) begin
    if (pass_pulse) pc++;
    if (fail_pulse) fc++;
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick;
    do @(negedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic toggle;
    dem = ~dem;
  endtask

  // Enable, pass through startup (with an ignored edge), stop just after entry to check.
  task automatic go_check;
    int k = 0, p0, f0;
    p0 = pc; f0 = fc;
    en = 1'b1;
    while (mode != 2'd2 && k < 12) begin
      wait_tick;
      k++;
      if (k == 2) toggle;
    end
    chk(k == 4, "R2 startup length in ticks", k, 4);
    chk(pc == p0 && fc == f0, "R2 no pulse during startup", pc + fc, p0 + f0);
  endtask

  task automatic stop;
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // {lo, hi, ticks waited, outcome 0 pass / 1 edge fail / 2 overflow fail}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'd14, 8'd24, 8'd13, 8'd0},
    {8'd14, 8'd24, 8'd22, 8'd0},
    {8'd14, 8'd24, 8'd12, 8'd1},
    {8'd14, 8'd24, 8'd23, 8'd2},
    {8'd4,  8'd8,  8'd5,  8'd0},
    {8'd10, 8'd10, 8'd5,  8'd1},
    {8'd4,  8'd8,  8'd2,  8'd1},
    {8'd20, 8'd40, 8'd25, 8'd0},
    {8'd12, 8'd10, 8'd5,  8'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == 2'd0, "R1 reset mode", mode, 0);
    chk(!pass_pulse && !fail_pulse && !done, "R1 reset outputs", {pass_pulse, fail_pulse, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mode == 2'd0 && pc == 0 && fc == 0, "R1 idle after reset", mode, 0);

    for (int v = 0; v < NV; v++) begin
      int n, e, p0, f0, fa;
      string tag;
      lo = VEC[v][31:24]; hi = VEC[v][23:16];
      n = VEC[v][15:8];   e = VEC[v][7:0];
      tag = (e == 0) ? "R4 pass" : (e == 2) ? "R6 overflow" :
            (lo >= hi) ? "R7 empty window" : "R5 early edge";
      repeat (2) @(negedge clk);
      go_check;
      wait_tick; toggle;                 // R3 first edge only arms
      p0 = pc; f0 = fc;
      repeat (n) wait_tick;
      toggle;
      repeat (2) @(negedge clk);
      fa = fc - f0;
      repeat (4) @(negedge clk);
      chk(pc - p0 == (e == 0 ? 1 : 0), {tag, " pass count"}, pc - p0, e == 0 ? 1 : 0);
      chk(fc - f0 == (e == 0 ? 0 : 1), {tag, " fail count"}, fc - f0, e == 0 ? 0 : 1);
      if (e != 0) begin
        chk(fa == (e == 2 ? 1 : 0), {tag, " fail before edge"}, fa, e == 2 ? 1 : 0);
        repeat (3) wait_tick;
        chk(mode == 2'd0, "R10 held in sleep after fail", mode, 0);
      end else begin
        chk(mode == 2'd2, "R4 still checking", mode, 2);
      end
      stop;
      chk(mode == 2'd0, "R10 disable to sleep", mode, 0);
    end

    // R8: limits changed after check entry must not apply.
    begin
      int p0, f0;
      lo = 8'd14; hi = 8'd24;
      repeat (2) @(negedge clk);
      go_check;
      lo = 8'd2; hi = 8'd6;
      wait_tick; toggle;
      p0 = pc; f0 = fc;
      repeat (15) wait_tick;
      toggle;
      repeat (6) @(negedge clk);
      chk(pc - p0 == 1 && fc == f0, "R8 captured limits used", pc - p0, 1);
      stop;
    end

    // R9: consecutive passes reach receive, then quiet; R10 disable with no fail.
    begin
      int p0, f0;
      lo = 8'd4; hi = 8'd8;
      repeat (2) @(negedge clk);
      go_check;
      wait_tick; toggle;
      p0 = pc; f0 = fc;
      for (int i = 0; i < 3; i++) begin
        repeat (4) wait_tick;
        toggle;
      end
      repeat (6) @(negedge clk);
      chk(pc - p0 == 3, "R9 three passes", pc - p0, 3);
      chk(mode == 2'd3 && done, "R9 receive mode", mode, 3);
      p0 = pc;
      wait_tick; toggle;
      repeat (12) wait_tick;
      toggle;
      repeat (6) @(negedge clk);
      chk(pc == p0 && fc == f0, "R9 no pulses in receive", pc + fc - p0 - f0, 0);
      chk(mode == 2'd3, "R9 receive held", mode, 3);
      en = 1'b0;
      @(negedge clk);
      chk(mode == 2'd0 && !done, "R10 receive to sleep", mode, 0);
      repeat (3) @(negedge clk);
      chk(fc == f0, "R10 no fail on disable", fc - f0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule